// File: doc/BRIEF.md
# CPU Trap Detection and Flagging Unit

This unit sits beside the execution pipeline of a 16-bit controller. It raises hardware traps for four conditions: stack overflow, stack underflow, undefined opcode and protection fault. It watches every stack-pointer update, each tagged with the kind of operation that moved the pointer. It also watches each decoded instruction, which arrives with its decoder-supplied validity flag and its second instruction word. Two software-writable limit registers bound the stack region. A sticky flag register records every cause that has fired.

For each cycle in which at least one cause fires, the unit issues one trap request in the following cycle. The request carries a two-bit vector identifier and the instruction-pointer value that the push sequence must save. That value is the address of the faulting instruction, the next instruction, or the one after next, depending on the cause and on what moved the stack pointer. A protected instruction passes only when its second word holds the opcode in the low byte and the bitwise inverse of the opcode in the high byte.

Top module: `trap_sentry`

## Requirements
- R1: After a synchronous reset the flag register reads 0, the overflow limit reads 0x0000, the underflow limit reads 0xFFFF and no trap is requested, so no stack update can trap until the limits are written.
- R2: A stack update whose kind is a decrement (kind bit 0 = 0) with a new pointer strictly below the overflow limit sets flag bit 0 and, one cycle later, requests vector 0.
- R3: A stack update whose kind is an increment (kind bit 0 = 1) with a new pointer strictly above the underflow limit sets flag bit 1 and, one cycle later, requests vector 1.
- R4: A new pointer equal to a limit, or a pointer beyond a limit reached by a move in the other direction, raises no trap.
- R5: A valid instruction flagged as not defined sets flag bit 2, requests vector 2 and pushes the current instruction address.
- R6: A defined instruction whose opcode is one of 0xC3, 0xC5, 0xC6, 0xC9, 0xCA, 0xCC and whose second word is not {~opcode, opcode} sets flag bit 3, requests vector 3 and pushes the current instruction address. A correct guard word, or any other opcode, raises no trap.
- R7: For a stack trap from an implicit move (kind bit 1 = 0: push, call, pop, return, entry), the pushed address is the next instruction address.
- R8: For a stack trap from explicit arithmetic on the pointer (kind bit 1 = 1), the pushed address is the address after the next instruction.
- R9: When several causes fire in one cycle, a single request is made for the highest-priority one (overflow, underflow, undefined, protection, in that order), and every firing cause sets its flag.
- R10: Flag bits are sticky. A flag write (select 2) clears exactly the bits written as 0 and leaves bits written as 1 unchanged.
- R11: A flag set by hardware in the same cycle as a software clear of that bit stays set.
- R12: A write with select 0 loads the overflow limit and a write with select 1 loads the underflow limit. Each reads back on its output from the next cycle, and the comparison in the write cycle uses the old value.
- R13: Stack and instruction inputs are ignored while their valid strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sp_upd_valid | input | 1 | Stack pointer update strobe |
| sp_upd_kind | input | 2 | Bit 0: 1 = increment, 0 = decrement; bit 1: 1 = explicit arithmetic, 0 = implicit |
| sp_new | input | 16 | Stack pointer value after the update |
| instr_valid | input | 1 | Decoded instruction strobe |
| op_defined | input | 1 | Decoder reports the opcode as defined |
| instr_op | input | 8 | Opcode byte |
| instr_word2 | input | 16 | Second instruction word |
| cur_ip | input | 16 | Address of the current instruction |
| next_ip | input | 16 | Address of the following instruction |
| next2_ip | input | 16 | Address of the instruction after the following one |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 overflow limit, 1 underflow limit, 2 flags, 3 none |
| wr_data | input | 16 | Write data |
| trap_req | output | 1 | Trap request, one cycle after the cause |
| trap_vec | output | 2 | Vector identifier of the requested trap |
| push_ip | output | 16 | Instruction address to save, valid with trap_req |
| trap_flags | output | 4 | Sticky flags: bit 0 overflow, 1 underflow, 2 undefined, 3 protection |
| ovf_limit | output | 16 | Overflow limit register |
| unf_limit | output | 16 | Underflow limit register |

## Verification
The assertions assume that each strobe is a clean 0 or 1 in every cycle. They also assume that the three instruction addresses are stable in the cycle their strobe is sampled, since the pushed address is compared with the value seen one cycle earlier. The stimulus drives every input only once the outputs have settled after a clock edge, and it holds the inputs for exactly one edge. Limits are written before any traffic that depends on them, and flags are cleared between table rows, so the expected flag value of each row depends only on that row.

// File: rtl/trap_sentry_pkg.sv
package trap_sentry_pkg;

    localparam int ADDR_W    = 16;
    localparam int OP_W      = 8;
    localparam int NUM_CAUSE = 4;
    localparam int VEC_W     = $clog2(NUM_CAUSE);
    localparam int NUM_PROT  = 6;
    localparam int SEL_W     = 2;

    // cause index doubles as the vector identifier and the priority (0 highest)
    localparam int C_OVF   = 0;
    localparam int C_UNF   = 1;
    localparam int C_UNDEF = 2;
    localparam int C_PROT  = 3;

    typedef enum logic [1:0] {
        SPK_IMPL_DEC  = 2'b00,
        SPK_IMPL_INC  = 2'b01,
        SPK_ARITH_SUB = 2'b10,
        SPK_ARITH_ADD = 2'b11
    } sp_kind_e;

    typedef enum logic [SEL_W-1:0] {
        REG_OVF_LIM = 2'd0,
        REG_UNF_LIM = 2'd1,
        REG_FLAGS   = 2'd2,
        REG_NONE    = 2'd3
    } reg_sel_e;

    localparam logic [OP_W-1:0] PROT_OPS [NUM_PROT] = '{
        8'hC3, 8'hC5, 8'hC6, 8'hC9, 8'hCA, 8'hCC
    };

    typedef struct packed {
        logic [NUM_CAUSE-1:0] hit;
        logic                 stack_arith;
    } cause_t;

    typedef struct packed {
        logic              req;
        logic [VEC_W-1:0]  vec;
        logic [ADDR_W-1:0] ip;
    } trap_out_t;

    function automatic logic is_decrement(input logic [1:0] kind);
        return ~kind[0];
    endfunction

    function automatic logic is_arith(input logic [1:0] kind);
        return kind[1];
    endfunction

    function automatic logic guard_ok(input logic [OP_W-1:0] op,
                                      input logic [2*OP_W-1:0] w2);
        return (w2[OP_W-1:0] == op) && (w2[2*OP_W-1:OP_W] == ~op);
    endfunction

endpackage

// File: rtl/trap_limit_regs.sv
module trap_limit_regs
    import trap_sentry_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [AW-1:0]    wr_data,
    output logic [AW-1:0]    ovf_lim,
    output logic [AW-1:0]    unf_lim
);
    localparam logic [AW-1:0] OVF_RST = '0;
    localparam logic [AW-1:0] UNF_RST = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_lim <= OVF_RST;
            unf_lim <= UNF_RST;
        end else if (wr_en) begin
            if (wr_sel == REG_OVF_LIM) ovf_lim <= wr_data;
            if (wr_sel == REG_UNF_LIM) unf_lim <= wr_data;
        end
    end

    AST_OVF_LIM_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == REG_OVF_LIM) |=> (ovf_lim == $past(wr_data))); // R12
    AST_UNF_LIM_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == REG_UNF_LIM) |=> (unf_lim == $past(wr_data))); // R12
    AST_LIM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(ovf_lim) && $stable(unf_lim))); // R12
endmodule

// File: rtl/trap_cause_detect.sv
module trap_cause_detect
    import trap_sentry_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int OW  = OP_W,
    parameter int NP  = NUM_PROT
) (
    input  logic          sp_upd_valid,
    input  logic [1:0]    sp_upd_kind,
    input  logic [AW-1:0] sp_new,
    input  logic          instr_valid,
    input  logic          op_defined,
    input  logic [OW-1:0] instr_op,
    input  logic [2*OW-1:0] instr_word2,
    input  logic [AW-1:0] ovf_lim,
    input  logic [AW-1:0] unf_lim,
    output cause_t        cause
);
    logic [NP-1:0] prot_match;
    logic          is_prot;
    logic          dec_move;
    logic          inc_move;

    generate
        for (genvar g = 0; g < NP; g++) begin : g_prot
            assign prot_match[g] = (instr_op == PROT_OPS[g]);
        end
    endgenerate

    assign is_prot  = |prot_match;
    assign dec_move = sp_upd_valid &&  is_decrement(sp_upd_kind);
    assign inc_move = sp_upd_valid && !is_decrement(sp_upd_kind);

    always_comb begin
        cause                 = '0;
        cause.hit[C_OVF]      = dec_move && (sp_new < ovf_lim);
        cause.hit[C_UNF]      = inc_move && (sp_new > unf_lim);
        cause.hit[C_UNDEF]    = instr_valid && !op_defined;
        cause.hit[C_PROT]     = instr_valid && op_defined && is_prot &&
                                !guard_ok(instr_op, instr_word2);
        cause.stack_arith     = is_arith(sp_upd_kind);
    end

    always_comb begin
        assert ($onehot0(prot_match)); // R6
        assert (!(cause.hit[C_OVF] && cause.hit[C_UNF])); // R4
    end
endmodule

// File: rtl/trap_flag_reg.sv
module trap_flag_reg
    import trap_sentry_pkg::*;
#(
    parameter int NC = NUM_CAUSE,
    parameter int AW = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NC-1:0]    set_hit,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [AW-1:0]    wr_data,
    output logic [NC-1:0]    flags
);
    logic [NC-1:0] keep_mask;

    assign keep_mask = (wr_en && wr_sel == REG_FLAGS) ? wr_data[NC-1:0] : '1;

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & keep_mask) | set_hit;
    end

    generate
        for (genvar b = 0; b < NC; b++) begin : g_chk
            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
                (flags[b] && !(wr_en && wr_sel == REG_FLAGS && !wr_data[b]))
                |=> flags[b]); // R10
            AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
                set_hit[b] |=> flags[b]); // R11
            AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_sel == REG_FLAGS && !wr_data[b] && !set_hit[b])
                |=> !flags[b]); // R10
        end
    endgenerate
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_sentry_pkg::*;
#(
    parameter int NC = NUM_CAUSE,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  cause_t        cause,
    input  logic [AW-1:0] cur_ip,
    input  logic [AW-1:0] next_ip,
    input  logic [AW-1:0] next2_ip,
    output trap_out_t     tout
);
    trap_out_t     pick;
    logic [AW-1:0] stack_ip;
    logic [AW-1:0] cand_ip [NC];

    assign stack_ip = cause.stack_arith ? next2_ip : next_ip;

    always_comb begin
        cand_ip[C_OVF]   = stack_ip;
        cand_ip[C_UNF]   = stack_ip;
        cand_ip[C_UNDEF] = cur_ip;
        cand_ip[C_PROT]  = cur_ip;
    end

    always_comb begin
        pick = '0;
        for (int i = NC - 1; i >= 0; i--) begin
            if (cause.hit[i]) begin
                pick.req = 1'b1;
                pick.vec = VEC_W'(i);
                pick.ip  = cand_ip[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tout <= '0;
        else     tout <= pick;
    end

    AST_PRIO_OVF: assert property (@(posedge clk) disable iff (rst)
        cause.hit[C_OVF] |=> (tout.req && tout.vec == VEC_W'(C_OVF))); // R9
    AST_PRIO_UNF: assert property (@(posedge clk) disable iff (rst)
        (cause.hit[C_UNF] && !cause.hit[C_OVF])
        |=> (tout.req && tout.vec == VEC_W'(C_UNF))); // R9
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !(|cause.hit) |=> !tout.req); // R13
    AST_PROT_IP: assert property (@(posedge clk) disable iff (rst)
        (cause.hit == NC'(1 << C_PROT)) |=> (tout.ip == $past(cur_ip))); // R6
endmodule

// File: rtl/trap_sentry.sv
module trap_sentry
    import trap_sentry_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sp_upd_valid,
    input  logic [1:0]  sp_upd_kind,
    input  logic [15:0] sp_new,
    input  logic        instr_valid,
    input  logic        op_defined,
    input  logic [7:0]  instr_op,
    input  logic [15:0] instr_word2,
    input  logic [15:0] cur_ip,
    input  logic [15:0] next_ip,
    input  logic [15:0] next2_ip,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wr_data,
    output logic        trap_req,
    output logic [1:0]  trap_vec,
    output logic [15:0] push_ip,
    output logic [3:0]  trap_flags,
    output logic [15:0] ovf_limit,
    output logic [15:0] unf_limit
);
    cause_t    cause;
    trap_out_t tout;

    trap_limit_regs #(.AW(ADDR_W)) u_limits (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ovf_lim (ovf_limit),
        .unf_lim (unf_limit)
    );

    trap_cause_detect #(.AW(ADDR_W), .OW(OP_W), .NP(NUM_PROT)) u_detect (
        .sp_upd_valid (sp_upd_valid),
        .sp_upd_kind  (sp_upd_kind),
        .sp_new       (sp_new),
        .instr_valid  (instr_valid),
        .op_defined   (op_defined),
        .instr_op     (instr_op),
        .instr_word2  (instr_word2),
        .ovf_lim      (ovf_limit),
        .unf_lim      (unf_limit),
        .cause        (cause)
    );

    trap_flag_reg #(.NC(NUM_CAUSE), .AW(ADDR_W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_hit (cause.hit),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .flags   (trap_flags)
    );

    trap_arbiter #(.NC(NUM_CAUSE), .AW(ADDR_W)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .cause    (cause),
        .cur_ip   (cur_ip),
        .next_ip  (next_ip),
        .next2_ip (next2_ip),
        .tout     (tout)
    );

    assign trap_req = tout.req;
    assign trap_vec = tout.vec;
    assign push_ip  = tout.ip;

    AST_OVF_TRAP: assert property (@(posedge clk) disable iff (rst)
        (sp_upd_valid && !sp_upd_kind[0] && sp_new < ovf_limit)
        |=> (trap_req && trap_vec == 2'd0 && trap_flags[0])); // R2
    AST_UNF_FLAG: assert property (@(posedge clk) disable iff (rst)
        (sp_upd_valid && sp_upd_kind[0] && sp_new > unf_limit)
        |=> trap_flags[1]); // R3
    AST_IMPL_IP: assert property (@(posedge clk) disable iff (rst)
        (cause.hit[C_OVF] && !sp_upd_kind[1]) |=> (push_ip == $past(next_ip))); // R7
    AST_ARITH_IP: assert property (@(posedge clk) disable iff (rst)
        (cause.hit[C_OVF] && sp_upd_kind[1]) |=> (push_ip == $past(next2_ip))); // R8
    AST_UNDEF_IP: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !op_defined && !cause.hit[C_OVF] && !cause.hit[C_UNF])
        |=> (trap_req && trap_vec == 2'd2 && push_ip == $past(cur_ip))); // R5
    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (trap_flags == 4'd0 && !trap_req &&
                        ovf_limit == 16'h0000 && unf_limit == 16'hFFFF)); // R1
endmodule

// File: tb/test_trap_sentry.sv
module test_trap_sentry;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sp_upd_valid = 1'b0;
    logic [1:0]  sp_upd_kind = 2'd0;
    logic [15:0] sp_new = 16'h0;
    logic        instr_valid = 1'b0;
    logic        op_defined = 1'b0;
    logic [7:0]  instr_op = 8'h0;
    logic [15:0] instr_word2 = 16'h0;
    logic [15:0] cur_ip = 16'h1000;
    logic [15:0] next_ip = 16'h1002;
    logic [15:0] next2_ip = 16'h1006;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [15:0] wr_data = 16'h0;
    logic        trap_req;
    logic [1:0]  trap_vec;
    logic [15:0] push_ip;
    logic [3:0]  trap_flags;
    logic [15:0] ovf_limit;
    logic [15:0] unf_limit;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    trap_sentry i_trap_sentry (
        .clk(clk), .rst(rst),
        .sp_upd_valid(sp_upd_valid), .sp_upd_kind(sp_upd_kind), .sp_new(sp_new),
        .instr_valid(instr_valid), .op_defined(op_defined), .instr_op(instr_op),
        .instr_word2(instr_word2), .cur_ip(cur_ip), .next_ip(next_ip),
        .next2_ip(next2_ip), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .trap_req(trap_req), .trap_vec(trap_vec), .push_ip(push_ip),
        .trap_flags(trap_flags), .ovf_limit(ovf_limit), .unf_limit(unf_limit)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic        sv;
        logic [1:0]  kind;
        logic [15:0] sp;
        logic        iv;
        logic        def;
        logic [7:0]  op;
        logic [15:0] w2;
        logic        req;
        logic [1:0]  vec;
        logic [1:0]  ipsel;
        logic [3:0]  flags;
    } vec_t;

    // ipsel: 0 none, 1 cur_ip, 2 next_ip, 3 next2_ip; limits ovf=0x0100 unf=0xF000
    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{4'd2,  1'b1, 2'd0, 16'h00FE, 1'b0, 1'b0, 8'h00, 16'h0000, 1'b1, 2'd0, 2'd2, 4'b0001}, // R2 R7
        '{4'd8,  1'b1, 2'd2, 16'h0080, 1'b0, 1'b0, 8'h00, 16'h0000, 1'b1, 2'd0, 2'd3, 4'b0001}, // R8
        '{4'd4,  1'b1, 2'd0, 16'h0100, 1'b0, 1'b0, 8'h00, 16'h0000, 1'b0, 2'd0, 2'd0, 4'b0000}, // R4 equal
        '{4'd4,  1'b1, 2'd1, 16'h0050, 1'b0, 1'b0, 8'h00, 16'h0000, 1'b0, 2'd0, 2'd0, 4'b0000}, // R4 wrong dir
        '{4'd3,  1'b1, 2'd1, 16'hF002, 1'b0, 1'b0, 8'h00, 16'h0000, 1'b1, 2'd1, 2'd2, 4'b0010}, // R3 R7
        '{4'd8,  1'b1, 2'd3, 16'hFFFE, 1'b0, 1'b0, 8'h00, 16'h0000, 1'b1, 2'd1, 2'd3, 4'b0010}, // R8
        '{4'd4,  1'b1, 2'd1, 16'hF000, 1'b0, 1'b0, 8'h00, 16'h0000, 1'b0, 2'd0, 2'd0, 4'b0000}, // R4 equal
        '{4'd4,  1'b1, 2'd3, 16'h0010, 1'b0, 1'b0, 8'h00, 16'h0000, 1'b0, 2'd0, 2'd0, 4'b0000}, // R4 wrong dir
        '{4'd5,  1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 8'h12, 16'h0000, 1'b1, 2'd2, 2'd1, 4'b0100}, // R5
        '{4'd6,  1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 8'hC3, 16'h3CC3, 1'b0, 2'd0, 2'd0, 4'b0000}, // R6 good
        '{4'd6,  1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 8'hC3, 16'hC3C3, 1'b1, 2'd3, 2'd1, 4'b1000}, // R6 bad hi
        '{4'd6,  1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 8'hCC, 16'h33CC, 1'b0, 2'd0, 2'd0, 4'b0000}, // R6 good
        '{4'd6,  1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 8'hCC, 16'hCC33, 1'b1, 2'd3, 2'd1, 4'b1000}, // R6 swapped
        '{4'd6,  1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 8'h12, 16'h0000, 1'b0, 2'd0, 2'd0, 4'b0000}, // R6 other op
        '{4'd13, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 8'h12, 16'h0000, 1'b0, 2'd0, 2'd0, 4'b0000}, // R13
        '{4'd9,  1'b1, 2'd0, 16'h0010, 1'b1, 1'b0, 8'h12, 16'h0000, 1'b1, 2'd0, 2'd2, 4'b0101}, // R9
        '{4'd9,  1'b1, 2'd1, 16'hF100, 1'b1, 1'b1, 8'hC9, 16'h0000, 1'b1, 2'd1, 2'd2, 4'b1010}, // R9
        '{4'd13, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 8'hC5, 16'h0000, 1'b0, 2'd0, 2'd0, 4'b0000}, // R13
        '{4'd13, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 8'h00, 16'h0000, 1'b0, 2'd0, 2'd0, 4'b0000}  // R13
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sp_upd_valid = 1'b0;
        instr_valid  = 1'b0;
        op_defined   = 1'b0;
        wr_en        = 1'b0;
        wr_sel       = 2'd3;
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    function automatic logic [15:0] ip_of(input logic [1:0] s);
        case (s)
            2'd1:    return 16'h1000;
            2'd2:    return 16'h1002;
            2'd3:    return 16'h1006;
            default: return 16'h0000;
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        check("R1 flags", 32'(trap_flags), 32'h0);
        check("R1 ovf_limit", 32'(ovf_limit), 32'h0000);
        check("R1 unf_limit", 32'(unf_limit), 32'hFFFF);
        check("R1 trap_req", 32'(trap_req), 32'h0);
        // R1 reset limits block stack traps at the extremes
        sp_upd_valid = 1'b1; sp_upd_kind = 2'd0; sp_new = 16'h0000;
        tick();
        check("R1 dec to 0 no trap", 32'(trap_req), 32'h0);
        sp_upd_kind = 2'd1; sp_new = 16'hFFFF;
        tick();
        check("R1 inc to FFFF no trap", 32'(trap_req), 32'h0);
        idle_inputs();
        // R12 limit writes; comparison in write cycle uses old value
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h0100;
        sp_upd_valid = 1'b1; sp_upd_kind = 2'd0; sp_new = 16'h0050;
        tick();
        idle_inputs();
        check("R12 old limit in write cycle", 32'(trap_req), 32'h0);
        check("R12 ovf readback", 32'(ovf_limit), 32'h0100);
        write_reg(2'd1, 16'hF000);
        check("R12 unf readback", 32'(unf_limit), 32'hF000);
        check("R12 ovf kept", 32'(ovf_limit), 32'h0100);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = TBL[i];
            tag = $sformatf("R%0d vec%0d", v.rq, i);
            sp_upd_valid = v.sv; sp_upd_kind = v.kind; sp_new = v.sp;
            instr_valid = v.iv; op_defined = v.def; instr_op = v.op; instr_word2 = v.w2;
            tick();
            idle_inputs();
            check({tag, " req"}, 32'(trap_req), 32'(v.req));
            if (v.req) begin
                check({tag, " vec"}, 32'(trap_vec), 32'(v.vec));
                check({tag, " ip"}, 32'(push_ip), 32'(ip_of(v.ipsel)));
            end
            check({tag, " flags"}, 32'(trap_flags), 32'(v.flags));
            write_reg(2'd2, 16'h0000);
        end

        // R10 sticky flags and selective clear
        sp_upd_valid = 1'b1; sp_upd_kind = 2'd0; sp_new = 16'h0001;
        instr_valid = 1'b1; op_defined = 1'b0;
        tick();
        idle_inputs();
        repeat (3) tick();
        check("R10 flags held", 32'(trap_flags), 32'b0101);
        check("R10 req drops", 32'(trap_req), 32'h0);
        write_reg(2'd2, 16'h000F);
        check("R10 write ones keeps", 32'(trap_flags), 32'b0101);
        write_reg(2'd2, 16'h000E);
        check("R10 clear bit0 only", 32'(trap_flags), 32'b0100);
        write_reg(2'd2, 16'h0000);
        check("R10 clear all", 32'(trap_flags), 32'b0000);
        // R11 set beats clear
        instr_valid = 1'b1; op_defined = 1'b0;
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'h0000;
        tick();
        idle_inputs();
        check("R11 set wins", 32'(trap_flags), 32'b0100);
        // R12 select 3 writes nothing
        write_reg(2'd3, 16'h1234);
        check("R12 sel3 ovf", 32'(ovf_limit), 32'h0100);
        check("R12 sel3 unf", 32'(unf_limit), 32'hF000);
        check("R12 sel3 flags", 32'(trap_flags), 32'b0100);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule